// File: doc/BRIEF.md
# Windowed Pixel Scan Sequencer

This block walks a rectangular region of a square pixel array and tells the array and the converter behind it which pixel to sample, and when. A start pulse captures a window and a pixel-clock ratio. The window is given by a lower-left corner and an upper-right corner. The ratio comes from a 4-bit field. The block then produces row and column addresses together with a one-cycle sample strobe, at the rate of one pixel per pixel clock.

The pixel clock is not a separate clock. It is an enable that fires once every N system-clock cycles, where N is the field value plus one. Before the first row the block waits a long settling interval of pixel clocks. Before each later row it waits a short interval. When the last pixel of the window has been sampled, the block pulses an end-of-frame strobe and raises a done flag. The flag stays high until the next scan is started.

Top module: `win_scan_seq`

## Requirements
- R1: After a synchronous reset, `row_addr`, `col_addr`, `sample_vld`, `frame_end` and `scan_done` are all 0.
- R2: A `start` pulse seen while idle begins a scan and captures the window inputs. Rows are visited in ascending order from the bottom bound to the top bound, and within each row columns go in ascending order from the left bound to the right bound. During each `sample_vld` cycle, `row_addr` and `col_addr` give the pixel being sampled.
- R3: The pixel-clock enable fires once every `div_sel`+1 system cycles, with `div_sel` from 0 to 15. The value is captured at the start edge, so changing `div_sel` during a scan has no effect on that scan.
- R4: The first sample of a scan falls on pixel tick 181, which is 180 ticks of lead-in. If the start edge is cycle 0 and N = `div_sel`+1, that is system cycle 181·N−1.
- R5: Between the last sample of one row and the first sample of the next row there are 19 idle pixel ticks. For a window W pixels wide, the first sample of row index i falls on tick 181 + i·(W+19).
- R6: Samples within a row fall on consecutive pixel ticks, one pixel per tick. A scan yields exactly W·H samples.
- R7: If left > right, or bottom > top, or either upper bound is at or beyond 160, the scan covers the full array: rows 0..159 and columns 0..159.
- R8: `frame_end` is high for exactly the cycle of the final `sample_vld`. `scan_done` is 1 from the following cycle until the next accepted start, and it is 0 while a scan runs.
- R9: A `start` pulse while a scan is running is ignored. The scan's addresses, timing and sample count are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Scan start request, honoured only when idle |
| div_sel | input | 4 | Pixel-clock ratio minus one |
| win_left | input | 8 | Window lower-left column |
| win_bottom | input | 8 | Window lower-left row |
| win_right | input | 8 | Window upper-right column |
| win_top | input | 8 | Window upper-right row |
| row_addr | output | 8 | Row of the pixel being addressed |
| col_addr | output | 8 | Column of the pixel being addressed |
| sample_vld | output | 1 | One-cycle strobe: sample the addressed pixel now |
| frame_end | output | 1 | Strobe with the last sample of the window |
| scan_done | output | 1 | Set after a scan completes, cleared by the next start |

## Verification
Every result is tied to a cycle count taken from the start edge. The k-th sample (row index i, column index j) is due exactly at system cycle t·N−1, where t = 180 + i·(W+19) + j + 1. `frame_end` coincides with the last of these cycles, and `scan_done` is due one cycle later. The bench counts cycles from the accepted start edge, samples on the falling clock edge, and compares each observed strobe with the cycle, row and column it predicts for that sample index. An early, late, missing or extra strobe is therefore reported rather than absorbed.

// File: rtl/win_scan_pkg.sv
package win_scan_pkg;

    localparam int COORD_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_PIX
    } scan_st_e;

    typedef struct packed {
        logic [COORD_W-1:0] x0;
        logic [COORD_W-1:0] x1;
        logic [COORD_W-1:0] y0;
        logic [COORD_W-1:0] y1;
    } win_t;

    // Falls back to the whole array when the corners are crossed or out of range.
    function automatic win_t win_norm(input win_t w, input int dim);
        win_t r;
        if ((w.x0 > w.x1) || (w.y0 > w.y1) ||
            (int'(w.x1) >= dim) || (int'(w.y1) >= dim)) begin
            r.x0 = '0;
            r.y0 = '0;
            r.x1 = COORD_W'(dim - 1);
            r.y1 = COORD_W'(dim - 1);
        end else begin
            r = w;
        end
        return r;
    endfunction

endpackage

// File: rtl/win_scan_presc.sv
module win_scan_presc #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else begin
            if (load) div_q <= div_in;
            if (load || !run || tick) cnt_q <= '0;
            else                      cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q != '0) |=> !tick);   // R3

    AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |=> $stable(div_q));  // R3

endmodule

// File: rtl/win_scan_walk.sv
module win_scan_walk
    import win_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               init,
    input  win_t               win_in,
    input  logic               step,
    output logic [COORD_W-1:0] row,
    output logic [COORD_W-1:0] col,
    output logic               row_last,
    output logic               frame_last
);
    win_t win_q;

    assign row_last   = (col == win_q.x1);
    assign frame_last = row_last && (row == win_q.y1);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            row   <= '0;
            col   <= '0;
        end else if (init) begin
            win_q <= win_in;
            row   <= win_in.y0;
            col   <= win_in.x0;
        end else if (step) begin
            if (row_last) begin
                col <= win_q.x0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    AST_COL_IN_WIN: assert property (@(posedge clk) disable iff (rst)
        step |-> (col >= win_q.x0 && col <= win_q.x1));   // R2

    AST_ROW_IN_WIN: assert property (@(posedge clk) disable iff (rst)
        step |-> (row >= win_q.y0 && row <= win_q.y1));   // R2

endmodule

// File: rtl/win_scan_seq.sv
module win_scan_seq
    import win_scan_pkg::*;
#(
    parameter int ARRAY_DIM  = 160,
    parameter int FIRST_LEAD = 180,
    parameter int ROW_LEAD   = 19,
    parameter int DIV_W      = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic [COORD_W-1:0] win_left,
    input  logic [COORD_W-1:0] win_bottom,
    input  logic [COORD_W-1:0] win_right,
    input  logic [COORD_W-1:0] win_top,
    output logic [COORD_W-1:0] row_addr,
    output logic [COORD_W-1:0] col_addr,
    output logic               sample_vld,
    output logic               frame_end,
    output logic               scan_done
);
    localparam int LEAD_MAX = (FIRST_LEAD > ROW_LEAD) ? FIRST_LEAD : ROW_LEAD;
    localparam int LEAD_W   = $clog2(LEAD_MAX + 1);

    scan_st_e          state_q;
    logic [LEAD_W-1:0] lead_q;
    logic              tick;
    logic              accept;
    logic              busy;
    logic              row_last;
    logic              frame_last;
    win_t              win_raw;
    win_t              win_ok;

    assign busy    = (state_q != ST_IDLE);
    assign accept  = start && !busy;
    assign win_raw = '{x0: win_left, x1: win_right, y0: win_bottom, y1: win_top};
    assign win_ok  = win_norm(win_raw, ARRAY_DIM);

    assign sample_vld = (state_q == ST_PIX) && tick;
    assign frame_end  = sample_vld && frame_last;

    win_scan_presc #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .load   (accept),
        .div_in (div_sel),
        .tick   (tick)
    );

    win_scan_walk u_walk (
        .clk        (clk),
        .rst        (rst),
        .init       (accept),
        .win_in     (win_ok),
        .step       (sample_vld && !frame_last),
        .row        (row_addr),
        .col        (col_addr),
        .row_last   (row_last),
        .frame_last (frame_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            lead_q    <= '0;
            scan_done <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q   <= ST_LEAD;
                    lead_q    <= LEAD_W'(FIRST_LEAD - 1);
                    scan_done <= 1'b0;
                end
                ST_LEAD: if (tick) begin
                    if (lead_q == '0) state_q <= ST_PIX;
                    else              lead_q  <= lead_q - 1'b1;
                end
                ST_PIX: if (tick) begin
                    if (frame_last) begin
                        state_q   <= ST_IDLE;
                        scan_done <= 1'b1;
                    end else if (row_last) begin
                        state_q <= ST_LEAD;
                        lead_q  <= LEAD_W'(ROW_LEAD - 1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (scan_done && !busy));   // R8

    AST_DONE_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !scan_done);                   // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !sample_vld) |=>
            ($stable(row_addr) && $stable(col_addr) && busy));   // R9

    AST_NO_SAMPLE_IN_LEAD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LEAD) |-> !sample_vld);  // R4

endmodule

// File: tb/win_scan_seq_test.sv
module win_scan_seq_test;

    localparam int DIM = 160;
    localparam int FL  = 180;
    localparam int RL  = 19;
    localparam int WDOG_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] div_sel = '0;
    logic [7:0] win_left = '0, win_bottom = '0, win_right = '0, win_top = '0;
    logic [7:0] row_addr, col_addr;
    logic       sample_vld, frame_end, scan_done;

    int n_vec  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    win_scan_seq uut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .div_sel    (div_sel),
        .win_left   (win_left),
        .win_bottom (win_bottom),
        .win_right  (win_right),
        .win_top    (win_top),
        .row_addr   (row_addr),
        .col_addr   (col_addr),
        .sample_vld (sample_vld),
        .frame_end  (frame_end),
        .scan_done  (scan_done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_LIMIT) begin
            n_vec  = n_vec + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act cycle %0d exp below %0d", cyc, WDOG_LIMIT);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec = n_vec + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    // Scan one window and compare every strobe with the predicted cycle and address.
    task automatic run_scan(input int l, input int b, input int r, input int t,
                            input int dv, input bit poke);
        int x0, x1, y0, y1, w, h, n, total, k, exp_t, exp_c, last_c, seen_end;
        x0 = l; x1 = r; y0 = b; y1 = t;
        if (l > r || b > t || r >= DIM || t >= DIM) begin   // R7 fallback
            x0 = 0; y0 = 0; x1 = DIM - 1; y1 = DIM - 1;
        end
        w = x1 - x0 + 1;
        h = y1 - y0 + 1;
        n = dv + 1;
        total = w * h;
        last_c = (FL + (h - 1) * (w + RL) + w) * n - 1;
        k = 0;
        seen_end = 0;

        @(negedge clk);
        win_left = 8'(l); win_bottom = 8'(b); win_right = 8'(r); win_top = 8'(t);
        div_sel = 4'(dv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 done cleared at start", int'(scan_done), 0);
        for (int c = 0; c <= last_c + 1; c++) begin
            if (c > 0) @(negedge clk);
            if (sample_vld) begin
                if (k < total) begin
                    exp_t = FL + (k / w) * (w + RL) + (k % w) + 1;
                    exp_c = exp_t * n - 1;
                    check((k % w == 0) ? ((k == 0) ? "R4 first sample cycle" : "R5 row lead cycle")
                                       : "R6 in-row sample cycle", c, exp_c);
                    check("R2 row address", int'(row_addr), y0 + k / w);
                    check("R2 col address", int'(col_addr), x0 + k % w);
                    check("R8 frame_end with sample", int'(frame_end), (k == total - 1) ? 1 : 0);
                end else begin
                    check("R6 extra sample", k, total - 1);
                end
                k++;
            end else if (frame_end) begin
                check("R8 frame_end without sample", 1, 0);
            end
            if (frame_end) seen_end++;
            if (c == last_c) check("R8 done low in final cycle", int'(scan_done), 0);
            if (poke && c == 3) begin
                start = 1'b1;                      // R9 ignored request
                div_sel = 4'(15 - dv);             // R3 mid-scan change
            end else if (poke && c == 4) begin
                start = 1'b0;
            end
        end
        check("R6 sample count", k, total);
        check("R8 frame_end count", seen_end, 1);
        check("R8 done after frame", int'(scan_done), 1);
        repeat (3) @(negedge clk);
        check("R8 done held", int'(scan_done), 1);
        check("R9 no restart strobe", int'(sample_vld), 0);
    endtask

    initial begin
        int l, b, wd, ht, dv;
        void'($urandom(32'h1b5c_0007));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 row reset", int'(row_addr), 0);
        check("R1 col reset", int'(col_addr), 0);
        check("R1 vld reset", int'(sample_vld), 0);
        check("R1 end reset", int'(frame_end), 0);
        check("R1 done reset", int'(scan_done), 0);

        // Directed corners
        run_scan(159, 159, 159, 159, 15, 1'b1);   // single corner pixel, slowest clock, R9/R3
        run_scan(0, 70, 159, 70, 1, 1'b0);        // one full-width row
        run_scan(10, 20, 11, 22, 0, 1'b1);        // narrow, undivided
        run_scan(50, 5, 20, 9, 0, 1'b1);          // R7 crossed columns -> full array
        run_scan(3, 3, 6, 6, 3, 1'b0);

        // Random windows
        for (int i = 0; i < 8; i++) begin
            l  = int'($urandom % 150);
            b  = int'($urandom % 150);
            wd = 1 + int'($urandom % 7);
            ht = 1 + int'($urandom % 5);
            dv = int'($urandom % 16);
            run_scan(l, b, l + wd - 1, b + ht - 1, dv, ($urandom % 2) == 1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule